// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single general-purpose register channel that sits beside a free-running timer counter. A 4-bit mode code, loaded through a control write strobe, selects the channel's role. When the top bit of the code is 0, the channel compares the counter with its register. On each new match it drives an output pin low or high, or toggles it. The pin starts at an initial level chosen by the same code. When the top bit is 1, the channel captures the counter value into its register. The trigger is either a selected edge of an input pin or a count event reported by a neighbouring counter.

Software loads the register through a write port. A buffer-mode input turns the register into a plain holding register: writes still land, but no compare action and no capture takes place. The input pin passes through a two-flop synchronizer before edge detection. A capture stores the counter value on the clock after the detected trigger. Counter generation, prescaling and interrupt signalling live outside this block.

Top module: `timer_cc_channel`

## Requirements
- R1: After reset the mode code is 0000, the register reads 0, `pin_out` is 0 and `pin_oe` is 0.
- R2: A mode write takes effect on the clock edge that samples `ctl_wr_en`. On that same edge `pin_out` takes the initial level: 0 for codes 0001, 0010 and 0011, and 1 for codes 0101, 0110 and 0111. `pin_oe` is 1 exactly for these six codes. For every other code `pin_oe` is 0 and `pin_out` is 0.
- R3: In a driving compare code, a counter value equal to the register at clock edge N changes `pin_out` at edge N+1, never at N. The low two code bits select the action: 01 drives 0, 10 drives 1, 11 toggles.
- R4: One compare action is taken per entry into equality. A counter that stays equal to the register for many cycles causes a single action.
- R5: Code 1000 captures on a rising pin edge and code 1001 on a falling edge. If `pin_in` changes before clock edge P1, the register holds the counter value present at edge P4 and is unchanged after P3.
- R6: Codes 1010 and 1011 capture on both pin edges, with the R5 timing.
- R7: Codes 11xx ignore the pin and capture when `nbr_cnt_evt` is 1. An event sampled at edge P1 stores the counter value present at edge P2. When `nbr_fast_clk` is 1 the event causes no capture.
- R8: While `buf_mode` is 1 there is no compare action on the pin and no capture. Register writes still load.
- R9: A register write loads `reg_wr_data` on the next edge and wins over a capture on the same edge.
- R10: Compare codes never capture, and the two disabled codes (0000, 0100) and the capture codes keep `pin_out` at 0 even when the counter matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr_en | input | 1 | Mode code write strobe |
| ctl_wr_data | input | 4 | Mode code to load |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | CNT_W | Register value to load |
| buf_mode | input | 1 | Buffer mode: suppress compare and capture |
| cnt_val | input | CNT_W | Current timer counter value |
| pin_in | input | 1 | Asynchronous capture pin |
| nbr_cnt_evt | input | 1 | Neighbouring counter counted up or down this cycle |
| nbr_fast_clk | input | 1 | Neighbouring counter runs on the undivided clock |
| gr_val | output | CNT_W | Register contents |
| pin_out | output | 1 | Compare output level |
| pin_oe | output | 1 | Compare output enable |

## Verification
The bench sweeps all sixteen mode codes and checks the initial level and the enable each one produces. A design that decoded the initial-level bit wrong would start the pin at the wrong level, and one that enabled the output in a disabled or capture code would drive it when it should not. For compare codes, the bench samples the pin one cycle after the match and again a cycle later. This catches an action applied a cycle early or to the wrong level. It also holds the counter on the match value to expose a toggle that repeats every cycle. For capture, it runs the counter at one value per cycle and checks that the stored value is exactly the one present at the fourth edge. A design with a missing or extra synchronizer stage, or with a swapped edge polarity, stores a value that is off by one or captures on the wrong transition. The bench also checks that buffer mode, the fast-neighbour gate and a same-cycle register write each win over the capture path.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_TGL  = 2'b11
    } cmp_act_e;

    // A code drives the pin when it is a compare code with a non-zero action.
    function automatic logic code_drives(input logic [3:0] code);
        return !code[3] && (code[1:0] != 2'b00);
    endfunction

    // Level loaded into the pin when the code is written.
    function automatic logic code_init(input logic [3:0] code);
        return code_drives(code) && code[2];
    endfunction

endpackage

// File: rtl/tcc_pin_sync.sv
module tcc_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall
);
    localparam int SH_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [SH_W-1:0] sh;
    } sync_st_t;

    sync_st_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.sh = {sync_q.sh[SH_W-2:0], pin_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    // Bit SH_W-2 is the synchronized level; bit SH_W-1 is its previous value.
    assign rise = sync_q.sh[SH_W-2] & ~sync_q.sh[SH_W-1];
    assign fall = ~sync_q.sh[SH_W-2] & sync_q.sh[SH_W-1];

endmodule

// File: rtl/tcc_cmp_out.sv
module tcc_cmp_out
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drv_en,
    input  cmp_act_e         act,
    input  logic             ctl_wr_en,
    input  logic [3:0]       ctl_wr_data,
    input  logic             buf_mode,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] gr_val,
    output logic             pin_out,
    output logic             pin_oe
);
    typedef struct packed {
        logic eq_prev;
        logic hit;
        logic pin;
    } out_st_t;

    out_st_t out_d, out_q;
    logic    eq_now;

    always_comb begin
        eq_now        = (cnt_val == gr_val);
        out_d         = out_q;
        out_d.eq_prev = eq_now;
        out_d.hit     = drv_en && !buf_mode && eq_now && !out_q.eq_prev;
        if (ctl_wr_en) begin
            out_d.pin = code_init(ctl_wr_data);
            out_d.hit = 1'b0;
        end else if (!drv_en) begin
            out_d.pin = 1'b0;
        end else if (out_q.hit && !buf_mode) begin
            unique case (act)
                ACT_LOW:  out_d.pin = 1'b0;
                ACT_HIGH: out_d.pin = 1'b1;
                ACT_TGL:  out_d.pin = ~out_q.pin;
                default:  out_d.pin = out_q.pin;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pin_out = out_q.pin;
    assign pin_oe  = drv_en;

    assert_init_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_en && code_init(ctl_wr_data)) |=> pin_out);

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_q.hit && !ctl_wr_en && drv_en) |=> $stable(pin_out));

    assert_single_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.hit |=> !out_q.hit);

    assert_buf_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_mode && !ctl_wr_en && drv_en) |=> $stable(pin_out));

    assert_off_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> !pin_out);

endmodule

// File: rtl/tcc_capt_reg.sv
module tcc_capt_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       mode_q,
    input  logic             buf_mode,
    input  logic             rise,
    input  logic             fall,
    input  logic             nbr_evt,
    input  logic             nbr_fast,
    input  logic             reg_wr_en,
    input  logic [CNT_W-1:0] reg_wr_data,
    input  logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] gr_val
);
    typedef struct packed {
        logic             trig;
        logic [CNT_W-1:0] gr;
    } cap_st_t;

    cap_st_t cap_d, cap_q;
    logic    src_hit;

    always_comb begin
        if (mode_q[2])      src_hit = nbr_evt && !nbr_fast;
        else if (mode_q[1]) src_hit = rise || fall;
        else if (mode_q[0]) src_hit = fall;
        else                src_hit = rise;

        cap_d      = cap_q;
        cap_d.trig = mode_q[3] && !buf_mode && src_hit;
        if (reg_wr_en)
            cap_d.gr = reg_wr_data;
        else if (cap_q.trig && mode_q[3] && !buf_mode)
            cap_d.gr = cnt_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign gr_val = cap_q.gr;

    assert_buf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_mode && !reg_wr_en) |=> $stable(gr_val));

    assert_wr_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (gr_val == $past(reg_wr_data)));

    assert_cmp_nocap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[3] && !reg_wr_en) |=> $stable(gr_val));

endmodule

// File: rtl/timer_cc_channel.sv
module timer_cc_channel
    import tcc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr_en,
    input  logic [3:0]       ctl_wr_data,
    input  logic             reg_wr_en,
    input  logic [CNT_W-1:0] reg_wr_data,
    input  logic             buf_mode,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             pin_in,
    input  logic             nbr_cnt_evt,
    input  logic             nbr_fast_clk,
    output logic [CNT_W-1:0] gr_val,
    output logic             pin_out,
    output logic             pin_oe
);
    typedef struct packed {
        logic [3:0] mode;
    } top_st_t;

    top_st_t  top_d, top_q;
    logic     pin_rise, pin_fall;
    logic     drv_en;
    cmp_act_e act;

    always_comb begin
        top_d = top_q;
        if (ctl_wr_en) top_d.mode = ctl_wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign drv_en = code_drives(top_q.mode);
    assign act    = cmp_act_e'(top_q.mode[1:0]);

    tcc_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .rise   (pin_rise),
        .fall   (pin_fall)
    );

    tcc_cmp_out #(.CNT_W(CNT_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .drv_en      (drv_en),
        .act         (act),
        .ctl_wr_en   (ctl_wr_en),
        .ctl_wr_data (ctl_wr_data),
        .buf_mode    (buf_mode),
        .cnt_val     (cnt_val),
        .gr_val      (gr_val),
        .pin_out     (pin_out),
        .pin_oe      (pin_oe)
    );

    tcc_capt_reg #(.CNT_W(CNT_W)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_q      (top_q.mode),
        .buf_mode    (buf_mode),
        .rise        (pin_rise),
        .fall        (pin_fall),
        .nbr_evt     (nbr_cnt_evt),
        .nbr_fast    (nbr_fast_clk),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .cnt_val     (cnt_val),
        .gr_val      (gr_val)
    );

    assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_en |=> (top_q.mode == $past(ctl_wr_data)));

    assert_mode_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr_en |=> $stable(top_q.mode));

endmodule

// File: tb/timer_cc_channel_tb.sv
module timer_cc_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [3:0]  ctl_wr_data = '0;
    logic        reg_wr_en = 1'b0;
    logic [15:0] reg_wr_data = '0;
    logic        buf_mode = 1'b0;
    logic [15:0] cnt_val = '0;
    logic        pin_in = 1'b0;
    logic        nbr_cnt_evt = 1'b0;
    logic        nbr_fast_clk = 1'b0;
    logic [15:0] gr_val;
    logic        pin_out, pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    localparam logic [15:0] SENT = 16'h5A5A;

    always #5 clk = ~clk;

    timer_cc_channel #(.CNT_W(16), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .buf_mode(buf_mode),
        .cnt_val(cnt_val), .pin_in(pin_in), .nbr_cnt_evt(nbr_cnt_evt),
        .nbr_fast_clk(nbr_fast_clk), .gr_val(gr_val), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic wr_mode(input logic [3:0] code);
        @(negedge clk); ctl_wr_en = 1'b1; ctl_wr_data = code;
        @(negedge clk); ctl_wr_en = 1'b0;
    endtask

    task automatic wr_gr(input logic [15:0] v);
        @(negedge clk); reg_wr_en = 1'b1; reg_wr_data = v;
        @(negedge clk); reg_wr_en = 1'b0;
    endtask

    // Pin change at a negedge with counter c0; the counter advances by one per cycle.
    task automatic cap_pin(input logic v, input logic [15:0] c0, input logic hit, input string rq);
        wr_gr(SENT);
        cnt_val = c0; pin_in = v;
        @(negedge clk); cnt_val = c0 + 16'd1;
        @(negedge clk); cnt_val = c0 + 16'd2;
        @(negedge clk); chk({rq, " latency"}, int'(gr_val), int'(SENT)); cnt_val = c0 + 16'd3;
        @(negedge clk); chk(rq, int'(gr_val), hit ? int'(c0 + 16'd3) : int'(SENT));
    endtask

    task automatic cap_nbr(input logic fast, input logic [15:0] c0, input logic hit, input string rq);
        wr_gr(SENT);
        cnt_val = c0; nbr_fast_clk = fast; nbr_cnt_evt = 1'b1;
        @(negedge clk); nbr_cnt_evt = 1'b0; chk({rq, " latency"}, int'(gr_val), int'(SENT));
        cnt_val = c0 + 16'd1;
        @(negedge clk); chk(rq, int'(gr_val), hit ? int'(c0 + 16'd1) : int'(SENT));
        nbr_fast_clk = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 gr", int'(gr_val), 0);
        chk("R1 pin", int'(pin_out), 0);
        chk("R1 oe", int'(pin_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: every code, initial level and enable
        cnt_val = 16'h1234;
        for (int m = 0; m < 16; m++) begin
            logic drv, lvl;
            drv = (m < 8) && ((m % 4) != 0);
            lvl = drv && (m >= 4);
            wr_mode(4'(m));
            chk("R2 init", int'(pin_out), int'(lvl));
            chk("R2 oe", int'(pin_oe), int'(drv));
        end

        // R3: compare action latency and level for each driving code
        for (int m = 1; m < 8; m++) begin
            logic lvl, exp;
            if (m == 4) continue;
            lvl = (m >= 4);
            exp = ((m % 4) == 1) ? 1'b0 : ((m % 4) == 2) ? 1'b1 : !lvl;
            cnt_val = 16'd50;
            wr_gr(16'd100);
            wr_mode(4'(m));
            cnt_val = 16'd100;
            @(negedge clk); chk("R3 early", int'(pin_out), int'(lvl)); cnt_val = 16'd101;
            @(negedge clk); chk("R3 action", int'(pin_out), int'(exp));
        end

        // R4: held match toggles once; a fresh match toggles again
        cnt_val = 16'd50;
        wr_mode(4'b0011);
        cnt_val = 16'd100;
        repeat (6) @(negedge clk);
        chk("R4 held", int'(pin_out), 1);
        cnt_val = 16'd50;
        @(negedge clk); cnt_val = 16'd100;
        repeat (2) @(negedge clk);
        chk("R4 second", int'(pin_out), 0);

        // R8: buffer mode blocks compare action
        cnt_val = 16'd50;
        buf_mode = 1'b1;
        wr_mode(4'b0010);
        cnt_val = 16'd100;
        repeat (3) @(negedge clk);
        chk("R8 no action", int'(pin_out), 0);
        buf_mode = 1'b0;
        cnt_val = 16'd50;

        // R10: disabled and capture codes stay low on a match
        for (int k = 0; k < 4; k++) begin
            wr_mode(4'(k * 4));
            cnt_val = 16'd100;
            repeat (3) @(negedge clk);
            chk("R10 no drive", int'(pin_out), 0);
            cnt_val = 16'd50;
        end

        // R5 and R6: pin capture edge selection
        for (int m = 8; m < 12; m++) begin
            logic r_ok, f_ok;
            r_ok = (m == 8) || (m >= 10);
            f_ok = (m >= 9);
            wr_mode(4'(m));
            cap_pin(1'b1, 16'(16'h0200 + m * 16), r_ok, (m < 10) ? "R5 rise" : "R6 rise");
            cap_pin(1'b0, 16'(16'h0300 + m * 16), f_ok, (m < 10) ? "R5 fall" : "R6 fall");
        end

        // R7: neighbour source, fast gate, pin ignored
        for (int m = 12; m < 16; m++) begin
            wr_mode(4'(m));
            cap_nbr(1'b0, 16'(16'h0400 + m * 16), 1'b1, "R7 event");
            cap_nbr(1'b1, 16'(16'h0500 + m * 16), 1'b0, "R7 fast gate");
            cap_pin(1'b1, 16'(16'h0600 + m * 16), 1'b0, "R7 pin ignored");
            cap_pin(1'b0, 16'(16'h0700 + m * 16), 1'b0, "R7 pin ignored");
        end
        // R7: neighbour event ignored in a pin mode
        wr_mode(4'b1010);
        cap_nbr(1'b0, 16'h0800, 1'b0, "R7 pin mode");

        // R9: write wins over same-edge capture
        wr_mode(4'b1100);
        wr_gr(SENT);
        cnt_val = 16'h0900; nbr_cnt_evt = 1'b1;
        @(negedge clk); nbr_cnt_evt = 1'b0; reg_wr_en = 1'b1; reg_wr_data = 16'hABCD;
        cnt_val = 16'h0901;
        @(negedge clk); reg_wr_en = 1'b0;
        chk("R9 write wins", int'(gr_val), int'(16'hABCD));

        // R8: buffer mode blocks capture but not writes
        buf_mode = 1'b1;
        wr_gr(16'h1111);
        chk("R8 write", int'(gr_val), int'(16'h1111));
        cap_nbr(1'b0, 16'h0A00, 1'b0, "R8 nbr");
        wr_mode(4'b1010);
        cap_pin(1'b1, 16'h0B00, 1'b0, "R8 pin");
        cap_pin(1'b0, 16'h0C00, 1'b0, "R8 pin");
        buf_mode = 1'b0;

        // R10: compare code never captures
        wr_mode(4'b0010);
        cap_pin(1'b1, 16'h0D00, 1'b0, "R10 no capture");
        cap_pin(1'b0, 16'h0E00, 1'b0, "R10 no capture");
        cap_nbr(1'b0, 16'h0F00, 1'b0, "R10 no capture");

        finish_run();
    end
endmodule